// File: doc/BRIEF.md
# ARINC 429 Transmit FIFO Serializer

This block is the transmit side of an ARINC 429 style serial link. A host writes each word as two 16-bit halves on a shared input with two strobes. The first strobe captures the low half. The second strobe captures the high half and pushes the assembled 31-bit word into an eight-entry queue. Parity is not stored in the queue.

When transmit enable is high, queued words leave one after another on a two-rail return-to-zero output, least significant bit first. A parity bit computed at the start of each word is sent last. Every word is followed by a four-bit-time null on both rails. The bit time is 10 or 80 clock cycles. A bit-rate clock output marks each bit time. A ready flag goes high once the queue is empty and no data bit is on the line.

Top module: `a429_tx`

## Requirements
- R1: After reset (rst_ni low), tx_ready_o is 1, rail_hi_o, rail_lo_o and bit_clk_o are 0, and the queue is empty.
- R2: A rising edge on load_lo_i captures half_i[15:0] as word bits [15:0]. A later rising edge on load_lo_i overwrites that capture. A rising edge on load_hi_i takes half_i[14:0] as word bits [30:16] and pushes the assembled word.
- R3: The queue holds 8 words. A push into a full queue is dropped, and the stored entries are kept unchanged.
- R4: Strobes that arrive while tx_en_i is high are ignored and queue nothing.
- R5: When tx_en_i is high, the queue is non-empty and the line is idle, the first bit time starts one clock after the edge that samples this. Word bit 0 is sent first.
- R6: When short_word_i=0, a word is sent as bits 0..30 followed by parity (32 bit times). When short_word_i=1, it is sent as bits 0..23 followed by parity (25 bit times).
- R7: When par_even_i=0, the count of ones over the sent data bits plus parity is odd. When par_even_i=1, that count is even.
- R8: Each word is followed by exactly 4 bit times with both rails low. While more words are queued and tx_en_i stays high, the next word starts (N+4)·D cycles after the previous start, where N is the word length in bit times and D is the bit time in cycles.
- R9: D is 10 cycles when slow_rate_i=0 and 80 cycles when slow_rate_i=1. bit_clk_o is high for the first D/2 cycles of every data or gap bit time, and low when the line is idle.
- R10: A one drives rail_hi_o and a zero drives rail_lo_o, for the first D/2 cycles of the bit. Both rails are low for the rest of the bit time. The two rails are never high together.
- R11: tx_ready_o is high exactly when the queue is empty and no data bit is being sent. It rises on the first cycle after the last parity bit.
- R12: If tx_en_i falls during a word, that word and its gap still complete. After that no new word starts, and the remaining words stay queued for a later enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| half_i | input | 16 | Halfword input for both load strobes |
| load_lo_i | input | 1 | Low-half strobe, acts on its rising edge |
| load_hi_i | input | 1 | High-half strobe and push, acts on its rising edge |
| tx_en_i | input | 1 | Transmit enable; loading is locked while it is high |
| par_even_i | input | 1 | 0 selects odd parity, 1 selects even parity |
| slow_rate_i | input | 1 | 0 selects a bit time of 10 cycles, 1 selects 80 cycles |
| short_word_i | input | 1 | 0 selects 31 data bits, 1 selects 24 data bits |
| rail_hi_o | output | 1 | Positive rail, return to zero |
| rail_lo_o | output | 1 | Negative rail, return to zero |
| bit_clk_o | output | 1 | Bit-rate clock, high in the first half of each bit time |
| tx_ready_o | output | 1 | Queue empty and no data bit on the line |

## Verification
The hardest situations to reach from the ports are a full queue with a ninth push, and transmit enable falling in the middle of a word while further words wait in the queue. The bench reaches the first by loading nine words with enable low. It reaches the second by dropping enable one cycle after the first word starts, then enabling again later. In both cases it compares every line cycle against a bench model of bit order, parity, null gap and ready timing. Strobes are also injected in the middle of a burst. An extra enabled word time that follows must stay silent.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/a429_tx_load.sv
module a429_tx_load #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned WORD_W = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              lo_stb_i,
  input  logic              hi_stb_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned UP_W = WORD_W - HALF_W;

  logic              lo_prev_q, hi_prev_q, push_q;
  logic [HALF_W-1:0] lo_half_q;
  logic [WORD_W-1:0] word_q;
  logic              lo_rise, hi_rise;

  assign lo_rise = lo_stb_i && !lo_prev_q && !lock_i;
  assign hi_rise = hi_stb_i && !hi_prev_q && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_prev_q <= 1'b0;
      hi_prev_q <= 1'b0;
      push_q    <= 1'b0;
      lo_half_q <= '0;
      word_q    <= '0;
    end else begin
      lo_prev_q <= lo_stb_i;
      hi_prev_q <= hi_stb_i;
      push_q    <= hi_rise;
      if (lo_rise) lo_half_q <= half_i;
      if (hi_rise) word_q <= {half_i[UP_W-1:0], lo_half_q};
    end
  end

  assign push_o = push_q;
  assign word_o = word_q;
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int unsigned WIDTH = 31,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= ptr_next(wptr_q);
      if (do_pop)  rptr_q <= ptr_next(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/a429_tx_rate.sv
module a429_tx_rate #(
  parameter int unsigned DIV_FAST = 10,
  parameter int unsigned DIV_SLOW = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic slow_i,
  output logic tick_o,
  output logic first_half_o
);
  localparam int unsigned DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int unsigned CNT_W   = $clog2(DIV_MAX);

  logic [CNT_W-1:0] cnt_q, limit, half;

  assign limit        = slow_i ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
  assign half         = slow_i ? CNT_W'(DIV_SLOW / 2) : CNT_W'(DIV_FAST / 2);
  assign tick_o       = run_i && (cnt_q >= limit);
  assign first_half_o = run_i && (cnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int unsigned WORD_W   = 31,
  parameter int unsigned SHORT_W  = 24,
  parameter int unsigned GAP_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              short_i,
  input  logic              even_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              tick_i,
  input  logic              first_half_i,
  output logic              pop_o,
  output logic              run_o,
  output logic              sending_o,
  output logic              rail_hi_o,
  output logic              rail_lo_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W + 1);
  localparam int unsigned GAP_W = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;

  tx_state_e         state_q;
  logic [WORD_W-1:0] sh_q, mask;
  logic              par_q, short_q, par_new, cur_bit, gap_done, start;
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic [GAP_W-1:0]  gcnt_q;

  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign mask[i] = !short_i || (i < SHORT_W);
  end

  assign par_new  = (^(fifo_data_i & mask)) ^ ~even_i;
  assign gap_done = (state_q == ST_GAP) && tick_i && (gcnt_q == GAP_W'(GAP_BITS - 1));
  assign start    = tx_en_i && !fifo_empty_i && ((state_q == ST_IDLE) || gap_done);
  assign last_idx = short_q ? IDX_W'(SHORT_W) : IDX_W'(WORD_W);
  assign cur_bit  = (idx_q == last_idx) ? par_q : sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      par_q   <= 1'b0;
      short_q <= 1'b0;
      idx_q   <= '0;
      gcnt_q  <= '0;
    end else if (start) begin
      state_q <= ST_DATA;
      sh_q    <= fifo_data_i;
      par_q   <= par_new;
      short_q <= short_i;
      idx_q   <= '0;
      gcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_DATA: if (tick_i) begin
          if (idx_q == last_idx) begin
            state_q <= ST_GAP;
            gcnt_q  <= '0;
          end else begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_GAP: if (tick_i) begin
          if (gap_done) state_q <= ST_IDLE;
          else          gcnt_q  <= gcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pop_o     = start;
  assign run_o     = (state_q != ST_IDLE);
  assign sending_o = (state_q == ST_DATA);
  assign rail_hi_o = sending_o && first_half_i && cur_bit;
  assign rail_lo_o = sending_o && first_half_i && !cur_bit;
endmodule

// File: rtl/a429_tx.sv
module a429_tx #(
  parameter int unsigned HALF_W   = 16,
  parameter int unsigned WORD_W   = 31,
  parameter int unsigned SHORT_W  = 24,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned GAP_BITS = 4,
  parameter int unsigned DIV_FAST = 10,
  parameter int unsigned DIV_SLOW = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] half_i,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic              tx_en_i,
  input  logic              par_even_i,
  input  logic              slow_rate_i,
  input  logic              short_word_i,
  output logic              rail_hi_o,
  output logic              rail_lo_o,
  output logic              bit_clk_o,
  output logic              tx_ready_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [WORD_W-1:0] in_word, fifo_word;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              run, tick, first_half, sending;

  a429_tx_load #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_load (
    .clk_i, .rst_ni,
    .lock_i   (tx_en_i),
    .half_i,
    .lo_stb_i (load_lo_i),
    .hi_stb_i (load_hi_i),
    .push_o   (fifo_push),
    .word_o   (in_word)
  );

  a429_tx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (fifo_push),
    .wdata_i (in_word),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_word),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_cnt)
  );

  a429_tx_rate #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
    .clk_i, .rst_ni,
    .run_i        (run),
    .slow_i       (slow_rate_i),
    .tick_o       (tick),
    .first_half_o (first_half)
  );

  a429_tx_ser #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .GAP_BITS(GAP_BITS)) u_ser (
    .clk_i, .rst_ni,
    .tx_en_i,
    .short_i      (short_word_i),
    .even_i       (par_even_i),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_word),
    .tick_i       (tick),
    .first_half_i (first_half),
    .pop_o        (fifo_pop),
    .run_o        (run),
    .sending_o    (sending),
    .rail_hi_o,
    .rail_lo_o
  );

  assign bit_clk_o  = first_half;
  assign tx_ready_o = fifo_empty && !sending;

  logic unused_full;
  assign unused_full = fifo_full;
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_en_i,
  input logic             rail_hi_o,
  input logic             rail_lo_o,
  input logic             bit_clk_o,
  input logic             tx_ready_o,
  input logic [CNT_W-1:0] fifo_cnt
);
  p_rails_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rail_hi_o && rail_lo_o));

  p_rz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_clk_o |-> (!rail_hi_o && !rail_lo_o));

  p_ready_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (!rail_hi_o && !rail_lo_o));

  p_load_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $past(tx_en_i)) |=> (fifo_cnt <= $past(fifo_cnt)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CNT_W'(DEPTH)) |=> (fifo_cnt >= CNT_W'(DEPTH - 1)));

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH));
endmodule

bind a429_tx a429_tx_chk #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .rail_hi_o  (rail_hi_o),
  .rail_lo_o  (rail_lo_o),
  .bit_clk_o  (bit_clk_o),
  .tx_ready_o (tx_ready_o),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/a429_tx_bench.sv
`timescale 1ns/1ps
module a429_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] half = '0;
  logic        load_lo = 1'b0, load_hi = 1'b0, tx_en = 1'b0;
  logic        par_even = 1'b0, slow = 1'b0, short_w = 1'b0;
  logic        rail_hi, rail_lo, bit_clk, tx_ready;

  int n_run = 0, n_fail = 0;
  logic [30:0] mq [8];
  int mq_n = 0;

  always #2.5 clk = ~clk;

  a429_tx u_a429_tx (
    .clk_i(clk), .rst_ni(rst_n), .half_i(half), .load_lo_i(load_lo),
    .load_hi_i(load_hi), .tx_en_i(tx_en), .par_even_i(par_even),
    .slow_rate_i(slow), .short_word_i(short_w), .rail_hi_o(rail_hi),
    .rail_lo_o(rail_lo), .bit_clk_o(bit_clk), .tx_ready_o(tx_ready)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [30:0] w, input logic sh, input logic ev);
    int ones = 0;
    for (int i = 0; i < (sh ? 24 : 31); i++) ones += w[i];
    return logic'(ones % 2) ^ !ev;
  endfunction

  task automatic strobe_lo(input logic [15:0] h);
    @(negedge clk); half = h; load_lo = 1'b1;
    @(negedge clk); load_lo = 1'b0;
  endtask

  task automatic strobe_hi(input logic [15:0] h);
    @(negedge clk); half = h; load_hi = 1'b1;
    @(negedge clk); load_hi = 1'b0;
  endtask

  task automatic load_word(input logic [30:0] w);
    strobe_lo(w[15:0]);
    strobe_hi({1'b0, w[30:16]});
    if (mq_n < 8) begin mq[mq_n] = w; mq_n++; end
  endtask

  // Enables transmission and compares every cycle against the model.
  task automatic run_burst(input int n_send, input bit drop, input bit inject, input string tag);
    int d, nb, nd, per, total, rem;
    int bad_rail, bad_clk, bad_rdy, ft_rail, ft_clk, ft_rdy;
    int act_rail, exp_rail, act_clk, exp_clk, act_rdy, exp_rdy;
    logic [30:0] bw [8];
    d = slow ? 80 : 10;
    nb = short_w ? 25 : 32;
    nd = nb - 1;
    per = (nb + 4) * d;
    total = n_send * per + per;
    for (int i = 0; i < n_send; i++) bw[i] = mq[i];
    for (int i = 0; i + n_send < 8; i++) mq[i] = mq[i + n_send];
    mq_n -= n_send;
    rem = mq_n;
    bad_rail = 0; bad_clk = 0; bad_rdy = 0; ft_rail = 0; ft_clk = 0; ft_rdy = 0;
    act_rail = 0; exp_rail = 0; act_clk = 0; exp_clk = 0; act_rdy = 0; exp_rdy = 0;
    @(negedge clk); tx_en = 1'b1;
    for (int t = 1; t <= total; t++) begin
      int w, off, b, ph, eh, el, ec, er;
      logic bv;
      @(negedge clk);
      w = (t - 1) / per; off = (t - 1) % per; b = off / d; ph = off % d;
      eh = 0; el = 0;
      if (w < n_send && b < nb && ph < d / 2) begin
        bv = (b < nd) ? bw[w][b] : par_of(bw[w], short_w, par_even);
        eh = int'(bv); el = int'(!bv);
      end
      ec = (w < n_send && ph < d / 2) ? 1 : 0;
      er = (rem == 0 && (t - 1) >= (n_send - 1) * per + nb * d) ? 1 : 0;
      if ({eh[0], el[0]} != {rail_hi, rail_lo}) begin
        if (bad_rail == 0) begin
          ft_rail = t; act_rail = {rail_hi, rail_lo}; exp_rail = {eh[0], el[0]};
        end
        bad_rail++;
      end
      if (ec[0] != bit_clk) begin
        if (bad_clk == 0) begin ft_clk = t; act_clk = bit_clk; exp_clk = ec; end
        bad_clk++;
      end
      if (er[0] != tx_ready) begin
        if (bad_rdy == 0) begin ft_rdy = t; act_rdy = tx_ready; exp_rdy = er; end
        bad_rdy++;
      end
      if (drop && t == 1) tx_en = 1'b0;
      if (inject) begin
        if (t == 3) begin half = 16'hA5A5; load_lo = 1'b1; end
        if (t == 4) begin load_lo = 1'b0; half = 16'h1234; load_hi = 1'b1; end
        if (t == 5) load_hi = 1'b0;
      end
    end
    tx_en = 1'b0;
    check(bad_rail == 0, tag, $sformatf("rail pair (first bad cycle %0d)", ft_rail), act_rail, exp_rail);
    check(bad_clk == 0, "R9", $sformatf("bit clock (first bad cycle %0d)", ft_clk), act_clk, exp_clk);
    check(bad_rdy == 0, "R11", $sformatf("ready flag (first bad cycle %0d)", ft_rdy), act_rdy, exp_rdy);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4291));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
    check({rail_hi, rail_lo, bit_clk} == 3'b000, "R1", "rails/clock after reset",
          {rail_hi, rail_lo, bit_clk}, 0);

    // R5 R6 R7: long words, odd parity, extreme patterns
    load_word(31'h0);
    load_word(31'h7FFF_FFFF);
    run_burst(2, 1'b0, 1'b0, "R7");

    // R6 R8: short words, even parity, back-to-back with gap
    short_w = 1'b1; par_even = 1'b1;
    load_word(31'h0055_AA01);
    load_word(31'h7F80_0000);
    load_word(31'h00FF_00FF);
    run_burst(3, 1'b0, 1'b0, "R8");
    short_w = 1'b0; par_even = 1'b0;

    // R2 repeated low strobe overwrites; high half bit 15 ignored
    strobe_lo(16'h1111);
    strobe_lo(16'hBEEF);
    strobe_hi(16'hC321);
    mq[mq_n] = {15'h4321, 16'hBEEF}; mq_n++;
    run_burst(1, 1'b0, 1'b0, "R2");

    // R3 nine pushes, eighth entry is the last one sent
    for (int i = 0; i < 9; i++) load_word(31'(32'h1357_0000 + 32'(i * 32'h0101_0101)));
    run_burst(8, 1'b0, 1'b0, "R3");

    // R9 slow rate, one short word
    slow = 1'b1; short_w = 1'b1;
    load_word(31'h0012_3456);
    run_burst(1, 1'b0, 1'b0, "R9");
    slow = 1'b0; short_w = 1'b0;

    // R12 enable dropped mid-word: only first word leaves, rest later
    load_word(31'h2AAA_AAAA);
    load_word(31'h1555_5555);
    load_word(31'h0F0F_0F0F);
    run_burst(1, 1'b1, 1'b0, "R12");
    check(tx_ready == 1'b0, "R12", "words kept after drop", tx_ready, 0);
    run_burst(2, 1'b0, 1'b0, "R12");

    // R4 strobes during a burst are ignored; next enabled window is silent
    load_word(31'h3333_CCCC);
    run_burst(1, 1'b0, 1'b1, "R4");
    run_burst(0, 1'b0, 1'b0, "R4");

    // R5 R10 random words and configurations
    for (int it = 0; it < 6; it++) begin
      int n;
      short_w = 1'($urandom % 2);
      par_even = 1'($urandom % 2);
      n = 1 + int'($urandom % 8);
      for (int k = 0; k < n; k++) load_word(31'($urandom));
      run_burst(n, 1'b0, 1'b0, "R10");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule